// File: doc/BRIEF.md
# Sticky Floating-Point Exception Status Register

This block keeps the exception status shared by a group of floating-point arithmetic units. Each unit has an update port with a write strobe, a guard bit and a vector of exception flags. The strobe is timed to match the cycle in which that unit writes its destination register. When the strobe is high and the guard is true, the unit's flags are ORed into the stored flags on that clock edge. The flags are sticky. An arithmetic result can only set them, and only an explicit register write can clear them.

The same register also holds the 2-bit rounding mode, which it drives to the arithmetic units at all times. Software writes the whole 32-bit word in one access and reads it back combinationally through a read port. A write and any number of unit updates may fall in the same cycle. In that case the written flags are taken first, and every qualified update is then ORed onto them.

Word layout:

| Bits | Content |
|---|---|
| [1:0] | Rounding mode: 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity |
| [2] | Invalid |
| [3] | Overflow |
| [4] | Underflow |
| [5] | Divide-by-zero |
| [6] | Inexact |
| [7] | Operand flushed to zero |
| [8] | Result flushed to zero |
| [31:9] | Read as zero |

Inside each unit's 7-bit flag vector, bit k maps to word bit 2+k.

Top module: `fpx_status_reg`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `csr_rdata` is 0. This means every flag is clear and the rounding mode is 0 (nearest-even).
- R2: When a unit has `upd_valid` and `upd_guard` both high on a clock edge, each set bit of its 7-bit flag vector (bit k goes to word bit 2+k) is set in `csr_rdata` from that edge onward.
- R3: An update whose guard bit is 0 changes no flag, even when its strobe is high.
- R4: Updates from several units on the same edge are merged. Each flag's new value is the OR of its current value and every qualified incoming value.
- R5: A flag that is set stays set across later updates, including updates that carry no flags. Only an explicit write clears it.
- R6: An explicit write (`csr_we` high on an edge) with no qualified update replaces the flags with `csr_wdata[8:2]` and the rounding mode with `csr_wdata[1:0]`. This is the only way to clear a flag.
- R7: When an explicit write and qualified updates occur on the same edge, the stored flags become the written flags ORed with all the updates' flags.
- R8: `round_mode` always equals `csr_rdata[1:0]`, and it changes only through an explicit write.
- R9: Bits [31:9] of `csr_rdata` always read as zero, whatever value is written.
- R10: A unit whose `upd_valid` is 0 changes no flag, even when its guard bit and flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 4 | Per-unit write strobe, aligned with the destination-register write |
| upd_guard | input | 4 | Per-unit guard bit; the update is used only when it is 1 |
| upd_flags | input | 28 | Per-unit 7-bit flag vectors; unit u occupies [7u+6:7u] |
| csr_we | input | 1 | Explicit register write enable |
| csr_wdata | input | 32 | Explicit register write data |
| csr_rdata | output | 32 | Whole register word, combinational from the stored state |
| round_mode | output | 2 | Rounding mode driven to the arithmetic units |

## Verification
The assertions assume that the flag vector on a port can only matter when both its strobe and its guard are high. They also assume that any number of ports, up to all four, may be qualified in a cycle at the same time as a write. The stimulus keeps a strong signal present on every masked port: it drives non-zero flags on ports that are gated off, whether by a low guard or a low strobe. It also drives all ports qualified at once, and it issues writes both alone and together with updates. This lets every merge and masking path be seen at `csr_rdata` on the cycle after the edge.

// File: rtl/fpx_status_pkg.sv
package fpx_status_pkg;

   localparam int FPX_FLAG_W  = 7;
   localparam int FPX_RM_W    = 2;
   localparam int FPX_FLAG_LSB = 2;

   // Flag index inside a unit's flag vector
   localparam int FLG_INVALID   = 0;
   localparam int FLG_OVERFLOW  = 1;
   localparam int FLG_UNDERFLOW = 2;
   localparam int FLG_DIV_ZERO  = 3;
   localparam int FLG_INEXACT   = 4;
   localparam int FLG_OPND_FLUSH = 5;
   localparam int FLG_RES_FLUSH  = 6;

   typedef enum logic [FPX_RM_W-1:0] {
      RM_NEAREST_EVEN = 2'd0,
      RM_TOWARD_ZERO  = 2'd1,
      RM_TOWARD_POS   = 2'd2,
      RM_TOWARD_NEG   = 2'd3
   } fpx_round_e;

endpackage

// File: rtl/fpx_update_merge.sv
module fpx_update_merge #(
   parameter int NUM_UNITS = 4,
   parameter int FLAG_W    = 7
) (
   input  logic [NUM_UNITS-1:0]        upd_valid,
   input  logic [NUM_UNITS-1:0]        upd_guard,
   input  logic [NUM_UNITS*FLAG_W-1:0] upd_flags,
   output logic [FLAG_W-1:0]           merged_flags
);

   logic [FLAG_W-1:0] gated [NUM_UNITS];

   // Per-unit qualification: strobe and guard LSB both required
   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      logic qual;
      assign qual     = upd_valid[u] & upd_guard[u];
      assign gated[u] = qual ? upd_flags[u*FLAG_W +: FLAG_W] : '0;
   end

   // OR reduction across units, one column per flag
   for (genvar k = 0; k < FLAG_W; k++) begin : g_col
      logic [NUM_UNITS-1:0] col;
      for (genvar u = 0; u < NUM_UNITS; u++) begin : g_tap
         assign col[u] = gated[u][k];
      end
      assign merged_flags[k] = |col;
   end

endmodule

// File: rtl/fpx_flag_store.sv
module fpx_flag_store
   import fpx_status_pkg::*;
#(
   parameter int FLAG_W = 7,
   parameter int RM_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [FLAG_W-1:0] wr_flags,
   input  logic [RM_W-1:0]   wr_rm,
   input  logic [FLAG_W-1:0] merged_flags,
   output logic [FLAG_W-1:0] flags_q,
   output logic [RM_W-1:0]   rm_q
);

   // One sticky cell per flag: write replaces, merge always ORs on top
   for (genvar k = 0; k < FLAG_W; k++) begin : g_cell
      always_ff @(posedge clk) begin
         if (!rst_n)
            flags_q[k] <= 1'b0;
         else if (wr_en)
            flags_q[k] <= wr_flags[k] | merged_flags[k];
         else
            flags_q[k] <= flags_q[k] | merged_flags[k];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rm_q <= RM_W'(RM_NEAREST_EVEN);
      else if (wr_en)
         rm_q <= wr_rm;
   end

   // R5: without a write no stored flag may drop
   p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

   // R2: every merged flag is present after the edge
   p_update_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|merged_flags) |=> ((flags_q & $past(merged_flags)) == $past(merged_flags)));

   // R6: a lone write lands exactly
   p_write_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && merged_flags == '0) |=> (flags_q == $past(wr_flags) && rm_q == $past(wr_rm)));

   // R3: no write and no qualified update leaves the state alone
   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && merged_flags == '0) |=> ($stable(flags_q) && $stable(rm_q)));

   // R8: rounding mode moves only on a write
   p_rm_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rm_q));

endmodule

// File: rtl/fpx_word_map.sv
module fpx_word_map #(
   parameter int DATA_W   = 32,
   parameter int FLAG_W   = 7,
   parameter int RM_W     = 2,
   parameter int FLAG_LSB = 2
) (
   input  logic [DATA_W-1:0] wdata,
   output logic [FLAG_W-1:0] wr_flags,
   output logic [RM_W-1:0]   wr_rm,
   input  logic [FLAG_W-1:0] flags_q,
   input  logic [RM_W-1:0]   rm_q,
   output logic [DATA_W-1:0] rdata
);

   localparam int USED_W = FLAG_LSB + FLAG_W;
   localparam int PAD_W  = DATA_W - USED_W;

   assign wr_rm    = wdata[RM_W-1:0];
   assign wr_flags = wdata[FLAG_LSB +: FLAG_W];

   if (PAD_W > 0) begin : g_pad
      logic unused_wbits;
      assign unused_wbits = ^wdata[DATA_W-1:USED_W];
      assign rdata = {{PAD_W{1'b0}}, flags_q, rm_q};
   end else begin : g_nopad
      assign rdata = {flags_q, rm_q};
   end

endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
   import fpx_status_pkg::*;
#(
   parameter int NUM_UNITS = 4,
   parameter int DATA_W    = 32,
   parameter int FLAG_W    = FPX_FLAG_W,
   parameter int RM_W      = FPX_RM_W,
   parameter int FLAG_LSB  = FPX_FLAG_LSB
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_UNITS-1:0]        upd_valid,
   input  logic [NUM_UNITS-1:0]        upd_guard,
   input  logic [NUM_UNITS*FLAG_W-1:0] upd_flags,
   input  logic                        csr_we,
   input  logic [DATA_W-1:0]           csr_wdata,
   output logic [DATA_W-1:0]           csr_rdata,
   output logic [RM_W-1:0]             round_mode
);

   localparam int USED_W = FLAG_LSB + FLAG_W;

   // Elaboration-time parameter checks
   if (NUM_UNITS < 1) begin : g_chk_units
      $error("fpx_status_reg: NUM_UNITS must be at least 1");
   end
   if (FLAG_LSB < RM_W) begin : g_chk_lsb
      $error("fpx_status_reg: flag field overlaps rounding mode");
   end
   if (USED_W > DATA_W) begin : g_chk_width
      $error("fpx_status_reg: fields do not fit in DATA_W");
   end

   logic [FLAG_W-1:0] merged_flags;
   logic [FLAG_W-1:0] wr_flags;
   logic [RM_W-1:0]   wr_rm;
   logic [FLAG_W-1:0] flags_q;
   logic [RM_W-1:0]   rm_q;

   fpx_update_merge #(
      .NUM_UNITS (NUM_UNITS),
      .FLAG_W    (FLAG_W)
   ) i_merge (
      .upd_valid    (upd_valid),
      .upd_guard    (upd_guard),
      .upd_flags    (upd_flags),
      .merged_flags (merged_flags)
   );

   fpx_flag_store #(
      .FLAG_W (FLAG_W),
      .RM_W   (RM_W)
   ) i_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (csr_we),
      .wr_flags     (wr_flags),
      .wr_rm        (wr_rm),
      .merged_flags (merged_flags),
      .flags_q      (flags_q),
      .rm_q         (rm_q)
   );

   fpx_word_map #(
      .DATA_W   (DATA_W),
      .FLAG_W   (FLAG_W),
      .RM_W     (RM_W),
      .FLAG_LSB (FLAG_LSB)
   ) i_map (
      .wdata    (csr_wdata),
      .wr_flags (wr_flags),
      .wr_rm    (wr_rm),
      .flags_q  (flags_q),
      .rm_q     (rm_q),
      .rdata    (csr_rdata)
   );

   assign round_mode = rm_q;

   // R8: driven mode matches the readable field
   p_rm_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
      round_mode == csr_rdata[RM_W-1:0]);

   // R9: padding bits read zero
   if (USED_W < DATA_W) begin : g_pad_chk
      p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
         csr_rdata[DATA_W-1:USED_W] == '0);
   end

   // R10/R3: a cycle with no qualified port and no write keeps the word
   p_masked_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!csr_we && ((upd_valid & upd_guard) == '0)) |=> $stable(csr_rdata));

endmodule

// File: tb/test_fpx_status_reg.sv
module test_fpx_status_reg;

   localparam int NU = 4;
   localparam int FW = 7;
   localparam int VW = 1 + 32 + NU + NU + NU*FW + 32;
   localparam int NV = 11;

   // {we, wdata, valid, guard, flags(unit3..unit0), expected rdata}
   localparam logic [VW-1:0] VEC [NV] = '{
      // 0 R2: unit0 div-zero + operand flush
      {1'b0, 32'h0, 4'b0001, 4'b0001, {7'h00, 7'h00, 7'h00, 7'h28}, 32'h0000_00A0},
      // 1 R3: guard low on unit1
      {1'b0, 32'h0, 4'b0010, 4'b0000, {7'h00, 7'h00, 7'h01, 7'h00}, 32'h0000_00A0},
      // 2 R10: strobe low on unit2
      {1'b0, 32'h0, 4'b0000, 4'b0100, {7'h00, 7'h02, 7'h00, 7'h00}, 32'h0000_00A0},
      // 3 R4: three units at once
      {1'b0, 32'h0, 4'b1011, 4'b1011, {7'h40, 7'h00, 7'h10, 7'h01}, 32'h0000_01E4},
      // 4 R5: empty update keeps flags
      {1'b0, 32'h0, 4'b0100, 4'b0100, {7'h00, 7'h00, 7'h00, 7'h00}, 32'h0000_01E4},
      // 5 R6: write clears flags, mode 3
      {1'b1, 32'h0000_0003, 4'b0000, 4'b0000, {7'h00, 7'h00, 7'h00, 7'h00}, 32'h0000_0003},
      // 6 R9: write all ones except bit0
      {1'b1, 32'hFFFF_FFFE, 4'b0000, 4'b0000, {7'h00, 7'h00, 7'h00, 7'h00}, 32'h0000_01FE},
      // 7 R7: write plus unit3 underflow
      {1'b1, 32'h0000_0001, 4'b1000, 4'b1000, {7'h04, 7'h00, 7'h00, 7'h00}, 32'h0000_0011},
      // 8 R7: write zero plus guarded-off unit1
      {1'b1, 32'h0000_0000, 4'b0010, 4'b0000, {7'h00, 7'h00, 7'h7F, 7'h00}, 32'h0000_0000},
      // 9 R4: all four units, distinct flags
      {1'b0, 32'h0, 4'b1111, 4'b1111, {7'h08, 7'h04, 7'h02, 7'h01}, 32'h0000_003C},
      // 10 R4: all four units, same flag
      {1'b0, 32'h0, 4'b1111, 4'b1111, {7'h40, 7'h40, 7'h40, 7'h40}, 32'h0000_013C}
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic [NU-1:0]     upd_valid;
   logic [NU-1:0]     upd_guard;
   logic [NU*FW-1:0]  upd_flags;
   logic              csr_we;
   logic [31:0]       csr_wdata;
   logic [31:0]       csr_rdata;
   logic [1:0]        round_mode;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   fpx_status_reg i_fpx_status_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_valid  (upd_valid),
      .upd_guard  (upd_guard),
      .upd_flags  (upd_flags),
      .csr_we     (csr_we),
      .csr_wdata  (csr_wdata),
      .csr_rdata  (csr_rdata),
      .round_mode (round_mode)
   );

   function automatic string vec_req(int i);
      case (i)
         0:       return "R2";
         1:       return "R3";
         2:       return "R10";
         3, 9, 10: return "R4";
         4:       return "R5";
         5:       return "R6";
         6:       return "R9";
         default: return "R7";
      endcase
   endfunction

   task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      upd_valid = '0;
      upd_guard = '0;
      upd_flags = '0;
      csr_we    = 1'b0;
      csr_wdata = '0;
   endtask

   initial begin
      #(20 * 5000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog (all requirements): actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1: value held in reset
      check32("R1", csr_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: after release
      check32("R1", csr_rdata, 32'h0);
      check32("R1", {30'h0, round_mode}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         v = VEC[i];
         csr_we    = v[VW-1];
         csr_wdata = v[VW-2 -: 32];
         upd_valid = v[VW-34 -: NU];
         upd_guard = v[VW-34-NU -: NU];
         upd_flags = v[VW-34-2*NU -: NU*FW];
         @(negedge clk);
         check32(vec_req(i), csr_rdata, v[31:0]);
         // R8: driven mode follows the field
         check32("R8", {30'h0, round_mode}, {30'h0, v[1:0]});
      end

      // R8: updates never move the rounding mode (currently 0)
      idle_inputs();
      csr_we = 1'b1; csr_wdata = 32'h0000_0002;
      @(negedge clk);
      idle_inputs();
      upd_valid = '1; upd_guard = '1; upd_flags = '1;
      @(negedge clk);
      check32("R8", {30'h0, round_mode}, 32'h2);
      check32("R2", csr_rdata, 32'h0000_01FE);

      // R10: unqualified ports after a clear leave the word at zero
      idle_inputs();
      csr_we = 1'b1; csr_wdata = 32'h0;
      @(negedge clk);
      idle_inputs();
      upd_valid = 4'b0101; upd_guard = 4'b1010; upd_flags = '1;
      @(negedge clk);
      check32("R10", csr_rdata, 32'h0);

      // R1: reset mid-run clears flags and mode
      idle_inputs();
      csr_we = 1'b1; csr_wdata = 32'h0000_01FF;
      @(negedge clk);
      idle_inputs();
      rst_n = 1'b0;
      @(negedge clk);
      check32("R1", csr_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check32("R1", csr_rdata, 32'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule